// File: doc/BRIEF.md
# Complementary Output Dead-Time Stage

This block turns one PWM reference into a pair of complementary drive signals, a main output and an inverted output. At every reference transition the output about to switch off drops at once. The output about to switch on waits a programmable dead time, so the pair is never active together. Both outputs are active high, and their inactive level is 0. The dead time is counted in pulses of a dead-time tick enable. Its length comes from an 8-bit setup code with a piecewise four-range encoding.

When the main output enable drops, the block enters an idle regime chosen by the off-state select input. With select 0 it releases the pads: both pad enables go low. With select 1 it keeps the pads driven. Both outputs first sit at the inactive level for one dead time, then take the two programmed idle levels.

The controller is a Moore state machine with seven states:
- `ST_FLOAT`: pads released. This is the reset state.
- `ST_IDLE_WAIT`: pads driven at the inactive level while the dead time counts.
- `ST_IDLE_HOLD`: pads driven at the idle levels.
- `ST_LO_WAIT` and `ST_LO_ON`: reference low, before and after the dead time.
- `ST_HI_WAIT` and `ST_HI_ON`: reference high, before and after the dead time.

The transitions are as follows:
- **Reference change:** any active state goes to the WAIT state of the new side, or straight to its ON state when the dead time is 0.
- **Expire:** a WAIT state goes to its ON or HOLD state.
- **Enable drop:** any active state goes to `ST_FLOAT` (select 0), or to `ST_IDLE_WAIT`/`ST_IDLE_HOLD` (select 1).
- **Select change while disabled:** moves between `ST_FLOAT` and the idle pair.
- **Enable return:** any idle state goes to the reference side through its dead time.

Top module: `cdt_stage`

## Requirements
- R1: For a setup code with bit 7 at 0, the dead time is code[6:0] ticks.
- R2: For code[7:6] = 10, the dead time is (64 + code[5:0]) × 2 ticks.
- R3: For code[7:5] = 110, the dead time is (32 + code[4:0]) × 8 ticks.
- R4: For code[7:5] = 111, the dead time is (32 + code[4:0]) × 16 ticks.
- R5: `out_main` and `out_comp` are never 1 in the same cycle.
- R6: On a reference rise with enable high, `out_comp` is 0 after the next clock edge. `out_main` becomes 1 only after the dead time has elapsed.
- R7: On a reference fall with enable high, `out_main` is 0 after the next clock edge. `out_comp` becomes 1 only after the dead time has elapsed.
- R8: A reference pulse shorter than the dead time leaves the output it would enable at 0 for that whole pulse.
- R9: With a dead time of 0, `out_main` equals the reference sampled at the previous clock edge, and `out_comp` equals its inverse.
- R10: The dead-time count advances only on cycles where `tick_en` is 1. It reloads from the decoded code at every transition.
- R11: With enable 0 and select 0, both pad enables and both outputs are 0 after the next clock edge.
- R12: With enable 0 and select 1, both pad enables stay 1. Both outputs are 0 for one dead time, then equal `idle_main`/`idle_comp`. A dead time of 0 gives the idle levels after the next clock edge.
- R13: When enable returns, the output matching the reference turns on only after one dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Dead-time tick enable |
| ref_in | input | 1 | PWM reference |
| dt_code | input | 8 | Dead-time setup code |
| moe | input | 1 | Main output enable |
| off_sel | input | 1 | Off-state select: 0 releases the pads, 1 drives the idle levels |
| idle_main | input | 1 | Idle level of the main output |
| idle_comp | input | 1 | Idle level of the complementary output |
| out_main | output | 1 | Main output data |
| out_comp | output | 1 | Complementary output data |
| oe_main | output | 1 | Pad enable for the main output |
| oe_comp | output | 1 | Pad enable for the complementary output |

## Verification
Every cycle, the assertions check the following:
- the pair is never both active;
- an output turns on only when the reference is on its side and the enable was high;
- no output turns on in a cycle without a tick while the reference and the enable are steady;
- the pad-enable state that follows each disabled regime is correct.

The exact dead-time length for each code range is visible only to the bench's scenarios. So are suppression of short pulses, the timed entry into the idle levels and the zero-delay following.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    localparam int DT_CODE_W = 8;
    localparam int DT_CNT_W  = 10;

    typedef enum logic [2:0] {
        ST_FLOAT     = 3'd0,
        ST_IDLE_WAIT = 3'd1,
        ST_IDLE_HOLD = 3'd2,
        ST_LO_WAIT   = 3'd3,
        ST_LO_ON     = 3'd4,
        ST_HI_WAIT   = 3'd5,
        ST_HI_ON     = 3'd6
    } cdt_state_e;
endpackage

// File: rtl/cdt_decode.sv
module cdt_decode #(
    parameter int CODE_W = cdt_pkg::DT_CODE_W,
    parameter int CNT_W  = cdt_pkg::DT_CNT_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  ticks,
    output logic              is_zero
);
    localparam int TOP = CODE_W - 1;

    always_comb begin
        unique casez (code[TOP -: 3])
            3'b0??:  ticks = CNT_W'(code[TOP-1:0]);
            3'b10?:  ticks = CNT_W'((CNT_W'(64) + CNT_W'(code[TOP-2:0])) << 1);
            3'b110:  ticks = CNT_W'((CNT_W'(32) + CNT_W'(code[TOP-3:0])) << 3);
            default: ticks = CNT_W'((CNT_W'(32) + CNT_W'(code[TOP-3:0])) << 4);
        endcase
    end

    assign is_zero = (ticks == '0);
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
    parameter int CNT_W = cdt_pkg::DT_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == '0) || (tick && cnt_q == CNT_W'(1));
endmodule

// File: rtl/cdt_fsm.sv
module cdt_fsm
    import cdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic moe,
    input  logic off_sel,
    input  logic dt_zero,
    input  logic expire,
    input  logic idle_main,
    input  logic idle_comp,
    output logic load,
    output logic out_main,
    output logic out_comp,
    output logic oe_main,
    output logic oe_comp
);
    cdt_state_e state_q, state_d;
    cdt_state_e go_hi, go_lo, go_idle;

    always_comb begin
        go_hi   = dt_zero ? ST_HI_ON : ST_HI_WAIT;
        go_lo   = dt_zero ? ST_LO_ON : ST_LO_WAIT;
        go_idle = dt_zero ? ST_IDLE_HOLD : ST_IDLE_WAIT;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!moe) begin
            if (!off_sel) begin
                state_d = ST_FLOAT;
            end else begin
                unique case (state_q)
                    ST_IDLE_WAIT: state_d = expire ? ST_IDLE_HOLD : ST_IDLE_WAIT;
                    ST_IDLE_HOLD: state_d = ST_IDLE_HOLD;
                    default:      state_d = go_idle;
                endcase
            end
        end else begin
            unique case (state_q)
                ST_LO_WAIT: state_d = ref_in ? go_hi : (expire ? ST_LO_ON : ST_LO_WAIT);
                ST_LO_ON:   state_d = ref_in ? go_hi : ST_LO_ON;
                ST_HI_WAIT: state_d = !ref_in ? go_lo : (expire ? ST_HI_ON : ST_HI_WAIT);
                ST_HI_ON:   state_d = !ref_in ? go_lo : ST_HI_ON;
                default:    state_d = ref_in ? go_hi : go_lo;
            endcase
        end
    end

    assign load = (state_d != state_q) &&
                  (state_d == ST_IDLE_WAIT || state_d == ST_LO_WAIT || state_d == ST_HI_WAIT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FLOAT;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        out_main = 1'b0;
        out_comp = 1'b0;
        oe_main  = 1'b1;
        oe_comp  = 1'b1;
        unique case (state_q)
            ST_FLOAT: begin
                oe_main = 1'b0;
                oe_comp = 1'b0;
            end
            ST_IDLE_HOLD: begin
                out_main = idle_main;
                out_comp = idle_comp;
            end
            ST_HI_ON: out_main = 1'b1;
            ST_LO_ON: out_comp = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/cdt_stage.sv
module cdt_stage #(
    parameter int CODE_W = cdt_pkg::DT_CODE_W,
    parameter int CNT_W  = cdt_pkg::DT_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              ref_in,
    input  logic [CODE_W-1:0] dt_code,
    input  logic              moe,
    input  logic              off_sel,
    input  logic              idle_main,
    input  logic              idle_comp,
    output logic              out_main,
    output logic              out_comp,
    output logic              oe_main,
    output logic              oe_comp
);
    logic [CNT_W-1:0] dt_ticks;
    logic             dt_zero;
    logic             load;
    logic             expire;

    cdt_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_decode (
        .code    (dt_code),
        .ticks   (dt_ticks),
        .is_zero (dt_zero)
    );

    cdt_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (dt_ticks),
        .tick     (tick_en),
        .expire   (expire)
    );

    cdt_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_in    (ref_in),
        .moe       (moe),
        .off_sel   (off_sel),
        .dt_zero   (dt_zero),
        .expire    (expire),
        .idle_main (idle_main),
        .idle_comp (idle_comp),
        .load      (load),
        .out_main  (out_main),
        .out_comp  (out_comp),
        .oe_main   (oe_main),
        .oe_comp   (oe_comp)
    );
endmodule

// File: rtl/cdt_stage_chk.sv
module cdt_stage_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_en,
    input logic ref_in,
    input logic moe,
    input logic off_sel,
    input logic out_main,
    input logic out_comp,
    input logic oe_main,
    input logic oe_comp
);
    // R5
    pair_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_main && out_comp));

    // R6
    main_on_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out_main) && $past(moe)) |-> $past(ref_in));

    // R7
    comp_on_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out_comp) && $past(moe)) |-> !$past(ref_in));

    // R10
    no_tick_no_turn_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && moe && $stable(moe) && $stable(ref_in)) |=>
            (!$rose(out_main) && !$rose(out_comp)));

    // R11
    release_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!moe && !off_sel) |=> (!oe_main && !oe_comp && !out_main && !out_comp));

    // R12
    keep_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!moe && off_sel) |=> (oe_main && oe_comp));
endmodule

bind cdt_stage cdt_stage_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .ref_in   (ref_in),
    .moe      (moe),
    .off_sel  (off_sel),
    .out_main (out_main),
    .out_comp (out_comp),
    .oe_main  (oe_main),
    .oe_comp  (oe_comp)
);

// File: tb/cdt_stage_tb.sv
module cdt_stage_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       ref_in = 1'b0;
    logic [7:0] dt_code = 8'd0;
    logic       moe = 1'b0;
    logic       off_sel = 1'b0;
    logic       idle_main = 1'b0;
    logic       idle_comp = 1'b0;
    logic       out_main, out_comp, oe_main, oe_comp;

    int n_checks = 0;
    int n_fail = 0;
    int n_overlap = 0;
    int tick_div = 1;
    int phase = 0;
    logic f_main, f_comp, f_oe;

    cdt_stage u_dut (
        .clk (clk), .rst_n (rst_n), .tick_en (tick_en), .ref_in (ref_in),
        .dt_code (dt_code), .moe (moe), .off_sel (off_sel),
        .idle_main (idle_main), .idle_comp (idle_comp),
        .out_main (out_main), .out_comp (out_comp),
        .oe_main (oe_main), .oe_comp (oe_comp)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (tick_div <= 1) begin
            tick_en = 1'b1;
        end else begin
            phase = (phase + 1) % tick_div;
            tick_en = (phase == 0);
        end
        if (rst_n && out_main && out_comp) n_overlap++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int dt_of(input int c);
        if (c < 128)      return c;
        else if (c < 192) return (64 + (c % 64)) * 2;
        else if (c < 224) return (32 + (c % 32)) * 8;
        else              return (32 + (c % 32)) * 16;
    endfunction

    function automatic string rtag(input int c);
        if (c < 128)      return "R1";
        else if (c < 192) return "R2";
        else if (c < 224) return "R3";
        else              return "R4";
    endfunction

    // Waits for the first edge after a stimulus, then counts edges until the
    // chosen output is 1; t counts ticks seen on those later edges.
    task automatic measure(input bit on_comp, output int n, output int t);
        logic tk;
        n = 0;
        t = 0;
        @(posedge clk); #1;
        f_main = out_main;
        f_comp = out_comp;
        f_oe = oe_main && oe_comp;
        while (((on_comp ? out_comp : out_main) == 1'b0) && n < 3000) begin
            #2;
            tk = tick_en;
            @(posedge clk); #1;
            n++;
            t += int'(tk);
        end
    endtask

    task automatic sweep_code(input int c);
        int n, t, d;
        d = dt_of(c);
        @(negedge clk); dt_code = 8'(c);
        @(negedge clk); ref_in = 1'b1;
        measure(1'b0, n, t);
        check(n == d, {rtag(c), "/R6 rise delay"}, n, d);
        check(!f_comp, "R6 comp off at once", int'(f_comp), 0);
        @(negedge clk); ref_in = 1'b0;
        measure(1'b1, n, t);
        check(n == d, {rtag(c), "/R7 fall delay"}, n, d);
        check(!f_main, "R7 main off at once", int'(f_main), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int n, t, seen;
        repeat (3) @(posedge clk);
        #1;
        check(!oe_main && !oe_comp, "R11 reset pads released", int'(oe_main) + int'(oe_comp), 0);
        check(!out_main && !out_comp, "R11 reset outputs", int'(out_main) + int'(out_comp), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk); #1;
        check(!oe_main && !oe_comp, "R11 disabled after reset", int'(oe_main), 0);

        @(negedge clk); moe = 1'b1;
        repeat (3) @(posedge clk); #1;
        check(out_comp && !out_main && oe_main && oe_comp, "R9 enabled low side", int'(out_comp), 1);

        // code sweep across all four ranges, with range boundaries
        for (int c = 0; c < 256; c += 5) sweep_code(c);
        sweep_code(127); sweep_code(128); sweep_code(191);
        sweep_code(192); sweep_code(223); sweep_code(224); sweep_code(255);

        // R9: zero dead time, toggle each cycle
        @(negedge clk); dt_code = 8'd0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); ref_in = (i % 3) != 0;
            @(posedge clk); #1;
            check(out_main == ref_in && out_comp == !ref_in, "R9 zero dead time follow",
                  int'(out_main), int'(ref_in));
        end

        // R8: short pulse
        @(negedge clk); ref_in = 1'b0; dt_code = 8'd10;
        repeat (20) @(posedge clk);
        @(negedge clk); ref_in = 1'b1;
        seen = 0;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            if (out_main) seen++;
        end
        @(negedge clk); ref_in = 1'b0;
        measure(1'b1, n, t);
        check(seen == 0 && !f_main, "R8 short pulse suppressed", seen, 0);
        check(n == 10, "R8 comp returns after dead time", n, 10);

        // R10: sparse ticks
        @(negedge clk); tick_div = 4; dt_code = 8'd5;
        @(negedge clk); ref_in = 1'b1;
        measure(1'b0, n, t);
        check(t == 5, "R10 rise counts ticks", t, 5);
        check(n >= 13, "R10 rise waits for sparse ticks", n, 17);
        @(negedge clk); ref_in = 1'b0;
        measure(1'b1, n, t);
        check(t == 5, "R10 fall counts ticks", t, 5);
        @(negedge clk); tick_div = 1;

        // R12: timed entry into idle levels
        @(negedge clk); ref_in = 1'b1; dt_code = 8'd20;
        idle_main = 1'b1; idle_comp = 1'b0; off_sel = 1'b1;
        repeat (30) @(posedge clk);
        @(negedge clk); moe = 1'b0;
        measure(1'b0, n, t);
        check(!f_main && !f_comp && f_oe, "R12 inactive first", int'(f_main), 0);
        check(n == 20, "R12 idle after dead time", n, 20);
        check(oe_main && oe_comp && !out_comp, "R12 idle levels", int'(out_comp), 0);

        // R11: switch to released while disabled
        @(negedge clk); off_sel = 1'b0;
        @(posedge clk); #1;
        check(!oe_main && !oe_comp && !out_main, "R11 pads released", int'(oe_main), 0);

        // R12: zero dead time gives idle levels at once
        @(negedge clk); dt_code = 8'd0; idle_main = 1'b0; idle_comp = 1'b1; off_sel = 1'b1;
        @(posedge clk); #1;
        check(out_comp && !out_main && oe_main && oe_comp, "R12 zero dead time idle",
              int'(out_comp), 1);

        // R13: enable returns with reference high
        @(negedge clk); dt_code = 8'd7; moe = 1'b1;
        measure(1'b0, n, t);
        check(!f_main && !f_comp, "R13 both off on return", int'(f_comp), 0);
        check(n == 7, "R13 dead time on return", n, 7);

        check(n_overlap == 0, "R5 pair overlap cycles", n_overlap, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule